// File: doc/BRIEF.md
# Frame-Mapped Tile Configuration Memory

This block holds the configuration of one fabric tile. A column of frame-select lines (one per frame) and a shared row of frame-data lines carry configuration into the tile. While a frame-select line is high, the storage cells of that frame take the values on the data lines. The stored bits are then spread into one flat tile configuration word, which feeds the tile's primitives and routing multiplexers. In that word, the first primitive's bits sit at the LSB end and the switch-matrix bits sit at the MSB end.

Each frame carries a used-bit mask. A cell exists only where the mask holds a 1. Where the mask holds a 0 there is a gap, and no storage is built for it. The number of cells in a frame is the number of ones in its mask.

Used cells reach the tile word in one of two ways:
- Packed mode (the default) walks the frames upward from frame 0 and each frame's bits from its MSB down. It hands out tile-word indices starting at the top of the word, so the MSBs of the word land in frame 0.
- Custom mode takes an explicit index for every frame slot from a parameter table, and this overrides the packed placement.

Capture is synchronous to the tile clock. A select line that is high at a rising edge loads that frame's used cells on that edge.

Top module: `tile_cfg_store`

## Requirements
- R1: `cfg_word` is `TILE_BITS` wide. While `rst_n` is low every stored bit is cleared, and `cfg_word` reads all zero until a frame is written.
- R2: When `frame_strobe[f]` is high at a rising clock edge, every used cell of frame f takes the matching `frame_data` bit. The new value shows on `cfg_word` after that edge, so the latency is one register. A later write to the same frame overwrites the earlier one.
- R3: At an edge where all `frame_strobe` bits are low, `cfg_word` keeps its value, whatever `frame_data` does.
- R4: In packed mode the used cells are visited in this order: frame 0 first, then upward; within each frame, bit `FRAME_BITS-1` down to bit 0. They receive tile indices `TILE_BITS-1`, `TILE_BITS-2`, and so on downward. With the default parameters (32-bit frames, 20 frames, 538-bit word), frame f for f below 16 puts data bit b at index 506-32f+b. Frame 16 uses data bits 31..6 at indices 25..0.
- R5: A frame position whose mask bit is 0 has no storage cell. The data line at that position never changes `cfg_word`. With the default masks, these are data bits 5..0 of frame 16.
- R6: Writing a frame whose mask is all zero changes nothing. With the default masks, these are frames 17, 18 and 19.
- R7: In custom mode, slot (f, b) reads its tile index from `REMAP[f*FRAME_BITS+b]`. The value -1 discards the slot. Gap slots stay empty whatever the table says.
- R8: A tile-word bit that no used cell reaches reads 0 at all times.
- R9: Several frame strobes high at the same edge each load their own used cells from the same `frame_data` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock; capture happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all stored bits |
| frame_strobe | input | NUM_FRAMES | One select line per frame; bit f loads frame f |
| frame_data | input | FRAME_BITS | Shared row of frame-data lines |
| cfg_word | output | TILE_BITS | Assembled tile configuration word |

## Verification
The bound checker covers the following on every cycle:
- the clear under reset;
- holding with all strobes low, whatever the data lines do;
- the placement of a full frame 0 at the top of the word in packed mode;
- the all-zero low bits left over when packed mode fills fewer bits than the word holds.

Only the bench scenarios can show the following:
- the exact bit placement of later frames, and the gap positions in the last partly used frame;
- the silent effect of frames with an empty mask;
- simultaneous writes to several frames;
- the custom index table, including discarded slots, gap slots that the table names, and tile bits that no slot reaches.

// File: rtl/tile_cfg_pkg.sv
package tile_cfg_pkg;

    typedef enum logic {
        MAP_PACKED = 1'b0,
        MAP_CUSTOM = 1'b1
    } map_mode_e;

    // Masks are handed to the helpers zero-extended to this width.
    localparam int MAX_FRAME_BITS = 64;

    // Number of mask ones strictly above a bit position (MSB-first rank).
    function automatic int ones_above(logic [MAX_FRAME_BITS-1:0] mask, int bit_pos);
        int n;
        n = 0;
        for (int i = 0; i < MAX_FRAME_BITS; i++) begin
            if (i > bit_pos && mask[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/tile_cfg_frame.sv
module tile_cfg_frame #(
    parameter int                  FRAME_BITS = 32,
    parameter logic [FRAME_BITS-1:0] USED_MASK  = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    input  logic [FRAME_BITS-1:0] line_data,
    output logic [FRAME_BITS-1:0] held_bits
);
    import tile_cfg_pkg::*;

    localparam int USED_CNT = $countones(USED_MASK);
    localparam int CELL_W   = (USED_CNT > 0) ? USED_CNT : 1;

    generate
        if (USED_CNT == 0) begin : g_empty
            // No cells: the frame contributes nothing.
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, strobe, line_data};
            assign held_bits     = '0;
        end else begin : g_cells
            typedef struct packed {
                logic [CELL_W-1:0] cells;
            } frame_state_t;

            frame_state_t       state_d;
            frame_state_t       state_q;
            logic [CELL_W-1:0]  packed_line;
            logic               unused_gap;

            assign unused_gap = ^(line_data & ~USED_MASK);

            for (genvar b = 0; b < FRAME_BITS; b++) begin : g_bit
                if (USED_MASK[b]) begin : g_used
                    localparam int POS =
                        ones_above(MAX_FRAME_BITS'(USED_MASK), b);
                    assign packed_line[POS] = line_data[b];
                    assign held_bits[b]     = state_q.cells[POS];
                end else begin : g_gap
                    assign held_bits[b] = 1'b0;
                end
            end

            always_comb begin
                state_d = state_q;
                if (strobe) begin
                    state_d.cells = packed_line;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= '0;
                end else begin
                    state_q <= state_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tile_cfg_router.sv
module tile_cfg_router #(
    parameter int                           FRAME_BITS  = 32,
    parameter int                           NUM_FRAMES  = 20,
    parameter int                           TILE_BITS   = 538,
    parameter logic [NUM_FRAMES*FRAME_BITS-1:0] FRAME_MASKS = '1,
    parameter tile_cfg_pkg::map_mode_e      MAP_MODE    = tile_cfg_pkg::MAP_PACKED,
    parameter int                           REMAP [NUM_FRAMES*FRAME_BITS] = '{default: -1}
) (
    input  logic [NUM_FRAMES*FRAME_BITS-1:0] slot_bits,
    output logic [TILE_BITS-1:0]             cfg_word
);
    import tile_cfg_pkg::*;

    localparam int SLOTS = NUM_FRAMES * FRAME_BITS;

    typedef int slot_map_t [SLOTS];

    function automatic slot_map_t build_map();
        slot_map_t m;
        int        next_idx;
        next_idx = TILE_BITS - 1;
        for (int f = 0; f < NUM_FRAMES; f++) begin
            for (int b = FRAME_BITS - 1; b >= 0; b--) begin
                int s;
                s = f * FRAME_BITS + b;
                if (!FRAME_MASKS[s]) begin
                    m[s] = -1;
                end else if (MAP_MODE == MAP_CUSTOM) begin
                    m[s] = REMAP[s];
                end else begin
                    m[s] = (next_idx >= 0) ? next_idx : -1;
                    next_idx--;
                end
            end
        end
        return m;
    endfunction

    localparam slot_map_t SLOT_IDX = build_map();

    // Elaboration-time wiring: each tile bit ORs the cells mapped onto it.
    always_comb begin
        cfg_word = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (SLOT_IDX[s] >= 0 && SLOT_IDX[s] < TILE_BITS) begin
                cfg_word[SLOT_IDX[s]] = cfg_word[SLOT_IDX[s]] | slot_bits[s];
            end
        end
    end

endmodule

// File: rtl/tile_cfg_store.sv
module tile_cfg_store #(
    parameter int                           FRAME_BITS  = 32,
    parameter int                           NUM_FRAMES  = 20,
    parameter int                           TILE_BITS   = 538,
    parameter logic [NUM_FRAMES*FRAME_BITS-1:0] FRAME_MASKS =
        {{3{32'h0000_0000}}, 32'hFFFF_FFC0, {16{32'hFFFF_FFFF}}},
    parameter tile_cfg_pkg::map_mode_e      MAP_MODE    = tile_cfg_pkg::MAP_PACKED,
    parameter int                           REMAP [NUM_FRAMES*FRAME_BITS] = '{default: -1}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] frame_strobe,
    input  logic [FRAME_BITS-1:0] frame_data,
    output logic [TILE_BITS-1:0]  cfg_word
);

    localparam int SLOTS = NUM_FRAMES * FRAME_BITS;

    logic [SLOTS-1:0] slot_bits;

    generate
        for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
            tile_cfg_frame #(
                .FRAME_BITS (FRAME_BITS),
                .USED_MASK  (FRAME_MASKS[f*FRAME_BITS +: FRAME_BITS])
            ) u_frame (
                .clk       (clk),
                .rst_n     (rst_n),
                .strobe    (frame_strobe[f]),
                .line_data (frame_data),
                .held_bits (slot_bits[f*FRAME_BITS +: FRAME_BITS])
            );
        end
    endgenerate

    tile_cfg_router #(
        .FRAME_BITS  (FRAME_BITS),
        .NUM_FRAMES  (NUM_FRAMES),
        .TILE_BITS   (TILE_BITS),
        .FRAME_MASKS (FRAME_MASKS),
        .MAP_MODE    (MAP_MODE),
        .REMAP       (REMAP)
    ) u_router (
        .slot_bits (slot_bits),
        .cfg_word  (cfg_word)
    );

endmodule

// File: rtl/tile_cfg_store_chk.sv
module tile_cfg_store_chk #(
    parameter int                           FRAME_BITS  = 32,
    parameter int                           NUM_FRAMES  = 20,
    parameter int                           TILE_BITS   = 538,
    parameter logic [NUM_FRAMES*FRAME_BITS-1:0] FRAME_MASKS = '1,
    parameter tile_cfg_pkg::map_mode_e      MAP_MODE    = tile_cfg_pkg::MAP_PACKED
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_FRAMES-1:0] frame_strobe,
    input logic [FRAME_BITS-1:0] frame_data,
    input logic [TILE_BITS-1:0]  cfg_word
);
    import tile_cfg_pkg::*;

    localparam int TOTAL_USED = $countones(FRAME_MASKS);

    // R1: a low reset leaves the word cleared on the next edge.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> cfg_word == '0);

    // R3: no strobe means no change.
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe == '0 |=> $stable(cfg_word));

    generate
        if (MAP_MODE == MAP_PACKED && TILE_BITS >= FRAME_BITS &&
            FRAME_MASKS[FRAME_BITS-1:0] == {FRAME_BITS{1'b1}}) begin : g_top
            // R4: a full frame 0 lands on the top FRAME_BITS of the word.
            assert_frame0_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
                frame_strobe[0] |=> cfg_word[TILE_BITS-1 -: FRAME_BITS] == $past(frame_data));
        end
        if (MAP_MODE == MAP_PACKED && TOTAL_USED < TILE_BITS) begin : g_low
            // R8: packing leaves the bottom of the word unreached.
            assert_unreached_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_word[TILE_BITS-TOTAL_USED-1:0] == '0);
        end
    endgenerate

endmodule

bind tile_cfg_store tile_cfg_store_chk #(
    .FRAME_BITS  (FRAME_BITS),
    .NUM_FRAMES  (NUM_FRAMES),
    .TILE_BITS   (TILE_BITS),
    .FRAME_MASKS (FRAME_MASKS),
    .MAP_MODE    (MAP_MODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .frame_data   (frame_data),
    .cfg_word     (cfg_word)
);

// File: tb/tb_tile_cfg_store.sv
module tb_tile_cfg_store;
    import tile_cfg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // Default instance: 32-bit frames, 20 frames, 538-bit word, packed.
    logic [19:0]  frame_strobe = '0;
    logic [31:0]  frame_data   = '0;
    logic [537:0] cfg_word;
    logic [537:0] exp_w = '0;

    tile_cfg_store dut (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .frame_data(frame_data), .cfg_word(cfg_word)
    );

    // Custom-map instance: 3 frames of 8 bits, 12-bit word.
    localparam int R_REMAP [24] = '{
        4, -1, -1, -1, 3, 2, 1, 0,
        8, 9, 10, 11, -1, -1, -1, -1,
        -1, -1, -1, -1, -1, -1, -1, 5
    };
    logic [2:0]  r_strobe = '0;
    logic [7:0]  r_data   = '0;
    logic [11:0] r_word;
    logic [11:0] r_exp = '0;

    tile_cfg_store #(
        .FRAME_BITS(8), .NUM_FRAMES(3), .TILE_BITS(12),
        .FRAME_MASKS(24'hA0_0F_F0), .MAP_MODE(MAP_CUSTOM), .REMAP(R_REMAP)
    ) dut_remap (
        .clk(clk), .rst_n(rst_n), .frame_strobe(r_strobe),
        .frame_data(r_data), .cfg_word(r_word)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct packed {
        logic [19:0] stb;
        logic [31:0] dat;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{20'h00001, 32'hDEADBEEF},   // R4 frame 0
        '{20'h08000, 32'h12345678},   // R4 frame 15
        '{20'h10000, 32'hFFFFFFFF},   // R4 R5 partial frame 16
        '{20'h00888, 32'hA5A55A5A},   // R9 frames 3,7,11 together
        '{20'h00001, 32'h00000000},   // R2 overwrite frame 0
        '{20'h00100, 32'hCAFEF00D},   // R4 frame 8
        '{20'hE0000, 32'hFFFFFFFF},   // R6 empty frames
        '{20'h10000, 32'h0000003F}    // R5 only gap lines high
    };

    // Reference model from R4/R5/R6.
    task automatic model_main(input logic [19:0] stb, input logic [31:0] dat);
        for (int f = 0; f < 16; f++)
            if (stb[f])
                for (int b = 0; b < 32; b++) exp_w[506 - 32*f + b] = dat[b];
        if (stb[16])
            for (int b = 6; b < 32; b++) exp_w[b - 6] = dat[b];
    endtask

    // Reference model from R7: table in R_REMAP above.
    task automatic model_remap(input logic [2:0] stb, input logic [7:0] dat);
        if (stb[0]) begin
            r_exp[0] = dat[7]; r_exp[1] = dat[6];
            r_exp[2] = dat[5]; r_exp[3] = dat[4];
        end
        if (stb[1])
            for (int i = 0; i < 4; i++) r_exp[8 + i] = dat[i];
        if (stb[2]) r_exp[5] = dat[7];
    endtask

    task automatic check_main(input string req);
        total++;
        if (cfg_word !== exp_w) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, cfg_word, exp_w);
        end
    endtask

    task automatic check_remap(input string req);
        total++;
        if (r_word !== r_exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, r_word, r_exp);
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, check at the next fall.
    task automatic apply_main(input logic [19:0] stb, input logic [31:0] dat);
        @(negedge clk);
        frame_strobe = stb;
        frame_data   = dat;
        @(negedge clk);
        frame_strobe = '0;
        model_main(stb, dat);
    endtask

    task automatic apply_remap(input logic [2:0] stb, input logic [7:0] dat);
        @(negedge clk);
        r_strobe = stb;
        r_data   = dat;
        @(negedge clk);
        r_strobe = '0;
        model_remap(stb, dat);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_main("R1 reset clear");
        check_remap("R1 reset clear custom");
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table.
        for (int i = 0; i < 8; i++) begin
            apply_main(VECS[i].stb, VECS[i].dat);
            check_main($sformatf("R2 R4 vector %0d", i));
        end

        // R3: data wiggles with no strobe.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            frame_data = 32'h1111_1111 * (i + 3);
        end
        @(negedge clk);
        check_main("R3 hold without strobe");

        // R5: gap lines differ, used lines identical -> same word.
        apply_main(20'h10000, 32'hFFFF_FFC0);
        check_main("R5 frame16 used bits");
        apply_main(20'h10000, 32'hFFFF_FFFF);
        check_main("R5 gap lines ignored");

        // R9: every loadable frame at once.
        apply_main(20'h1FFFF, 32'h0F0F_3C3C);
        check_main("R9 all frames together");

        // R6: empty frames cannot disturb it.
        apply_main(20'hE0000, 32'h0000_0000);
        check_main("R6 empty frames no effect");

        // Custom map.
        apply_remap(3'b001, 8'b1011_0001);
        check_remap("R7 custom frame0 incl gap slot");
        apply_remap(3'b010, 8'b1111_0110);
        check_remap("R7 custom frame1");
        apply_remap(3'b100, 8'hFF);
        check_remap("R7 R8 frame2 discard slot and unreached bits");
        apply_remap(3'b111, 8'hFF);
        check_remap("R9 custom all frames");
        total++;
        if (r_word[7:6] !== 2'b00 || r_word[4] !== 1'b0) begin
            bad++;
            $display("FAIL R8 unreached bits actual=%b%b%b expected=000",
                     r_word[7], r_word[6], r_word[4]);
        end

        // R1: reset mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        exp_w = '0;
        r_exp = '0;
        @(negedge clk);
        check_main("R1 reset mid-run");
        check_remap("R1 reset mid-run custom");
        rst_n = 1'b1;
        apply_main(20'h00002, 32'h8000_0001);
        check_main("R2 write after reset");

        finish_run();
    end

endmodule